// File: doc/BRIEF.md
# Privileged Special-Register Access Gate

This block sits between a core's instruction pipeline and its small set of special-purpose registers. It serves the two special-register move operations, read and write, and decides for each one whether it may proceed. The decision rests on three things: the caller's privilege, the requested address, and the kind of register at that address.

An accepted read returns the register's value. An accepted write updates the local storage, or it produces a side effect instead, such as a program-counter redirect. A rejected access has no architectural effect. It returns zero data on a read and pulses a warning strobe that carries the offending address, so that the event can be logged.

One request may be presented per cycle. Every response appears on registered outputs in the following cycle.

Top module: `spr_gate`

## Requirements
- R1: An access proceeds only when `mode_super_i` or `mode_usr_spr_i` is 1. Otherwise the access is refused:
  - a read completes with data 0;
  - a write changes no register;
  - `warn_o` pulses.
- R2: Any address at or above `SPR_LIMIT` (default 0x6000) is refused with a warning. A read of such an address returns 0.
- R3: The readable set is the following. A read of any of these sets `rf_re_o` and returns the register's value:
  - version (0x0000), unit-present (0x0001) and configuration (0x0002), which are parameter constants;
  - status (0x0011);
  - previous PC (0x0012), taken from `prev_pc_i`;
  - FP control/status (0x0014);
  - exception PC (0x0020);
  - MAC low (0x2801) and MAC high (0x2802);
  - the 512-entry shadow window 0x0400..0x05FF.
- R4: The store set is FP control/status, exception PC, exception status (0x0040), MAC low and high, and the shadow window. A write to any of these sets `rf_we_o` and stores the value, with no warning.
- R5: A write to status (0x0011) stores the value with bit 15 forced to 1 and sets `rf_we_o`. After reset, status reads 0x00008000.
- R6: A write to next-PC (0x0010) stores nothing. It pulses `redir_valid_o` with `redir_pc_o` equal to the written data, which also tells the core to clear any pending delay-slot state.
- R7: A write to the timer mode register (0x5000) is handled by value:
  - with data 0 it is accepted silently: no store, no warning;
  - with nonzero data it pulses `warn_o` only.
- R8: Every other access is refused with a warning and leaves all storage unchanged. This covers reads outside the readable set (for example exception status, next-PC or timer) and writes outside the write set (for example version).
- R9: The response to a request at clock edge k is visible after edge k, for one cycle:
  - `rd_valid_o` for every read;
  - `warn_o` together with `warn_addr_o` holding the request address, for every refused access.

  A read in the cycle after a write to the same register returns the new value.
- R10: While `rst` is high, every output is driven to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Special-register address |
| req_wdata_i | input | 32 | Write data |
| mode_super_i | input | 1 | Supervisor mode bit of the current status |
| mode_usr_spr_i | input | 1 | User special-register access permission bit |
| prev_pc_i | input | 32 | Previous program counter, readable at 0x0012 |
| rf_we_o | output | 1 | A write was stored |
| rf_re_o | output | 1 | A read was accepted |
| rd_valid_o | output | 1 | A read completed (accepted or refused) |
| rd_data_o | output | 32 | Read data, 0 when refused |
| redir_valid_o | output | 1 | PC redirect and delay-slot clear request |
| redir_pc_o | output | 32 | Redirect target |
| warn_o | output | 1 | Refused-access strobe |
| warn_addr_o | output | 16 | Address of the refused access |

## Verification
The embedded properties assume two things about the inputs: `req_valid_i` is a single-cycle qualifier, and the address, data and mode bits are stable around each rising edge. The properties that look one cycle back also assume that every request is sampled exactly once.

The bench drives all inputs on the falling edge and presents at most one request per cycle, with either back-to-back or gapped spacing. It holds `prev_pc_i` constant except between requests. It toggles the mode bits only together with a new request, so each request carries a single, well-defined privilege state.

// File: rtl/spr_gate_pkg.sv
package spr_gate_pkg;

    localparam int SPR_AW = 16;
    localparam int SPR_DW = 32;

    typedef logic [SPR_AW-1:0] spr_addr_t;
    typedef logic [SPR_DW-1:0] spr_word_t;

    // Address map of the single registers
    localparam spr_addr_t A_VERSION = 16'h0000;
    localparam spr_addr_t A_UNITS   = 16'h0001;
    localparam spr_addr_t A_CFG     = 16'h0002;
    localparam spr_addr_t A_NEXTPC  = 16'h0010;
    localparam spr_addr_t A_STATUS  = 16'h0011;
    localparam spr_addr_t A_PREVPC  = 16'h0012;
    localparam spr_addr_t A_FPCS    = 16'h0014;
    localparam spr_addr_t A_EXCPC   = 16'h0020;
    localparam spr_addr_t A_EXCSR   = 16'h0040;
    localparam spr_addr_t A_MACLO   = 16'h2801;
    localparam spr_addr_t A_MACHI   = 16'h2802;
    localparam spr_addr_t A_TIMER   = 16'h5000;

    localparam int FO_BIT = 15;

    typedef enum logic [3:0] {
        K_BAD, K_VERSION, K_UNITS, K_CFG, K_STATUS, K_PREVPC, K_FPCS,
        K_EXCPC, K_EXCSR, K_MACLO, K_MACHI, K_NEXTPC, K_TIMER, K_SHADOW
    } spr_kind_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_store;
        logic redirect;
        logic warn;
    } spr_act_t;

    function automatic logic kind_readable(spr_kind_e k);
        case (k)
            K_VERSION, K_UNITS, K_CFG, K_STATUS, K_PREVPC,
            K_FPCS, K_EXCPC, K_MACLO, K_MACHI, K_SHADOW: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

    function automatic logic kind_storable(spr_kind_e k);
        case (k)
            K_STATUS, K_FPCS, K_EXCPC, K_EXCSR,
            K_MACLO, K_MACHI, K_SHADOW: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic spr_word_t force_fixed_one(spr_word_t v);
        return v | (spr_word_t'(1) << FO_BIT);
    endfunction

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_gate_pkg::*;
#(
    parameter spr_addr_t SPR_LIMIT    = 16'h6000,
    parameter spr_addr_t SHADOW_BASE  = 16'h0400,
    parameter int        SHADOW_DEPTH = 512,
    localparam int       IDX_W        = $clog2(SHADOW_DEPTH)
) (
    input  logic             valid_i,
    input  logic             write_i,
    input  spr_addr_t        addr_i,
    input  spr_word_t        wdata_i,
    input  logic             priv_i,
    output spr_kind_e        kind_o,
    output logic [IDX_W-1:0] idx_o,
    output spr_act_t         act_o
);

    localparam spr_addr_t SHADOW_END = spr_addr_t'(32'(SHADOW_BASE) + SHADOW_DEPTH);

    always_comb begin
        kind_o = K_BAD;
        if (addr_i < SPR_LIMIT) begin
            if (addr_i >= SHADOW_BASE && addr_i < SHADOW_END) begin
                kind_o = K_SHADOW;
            end else begin
                case (addr_i)
                    A_VERSION: kind_o = K_VERSION;
                    A_UNITS:   kind_o = K_UNITS;
                    A_CFG:     kind_o = K_CFG;
                    A_NEXTPC:  kind_o = K_NEXTPC;
                    A_STATUS:  kind_o = K_STATUS;
                    A_PREVPC:  kind_o = K_PREVPC;
                    A_FPCS:    kind_o = K_FPCS;
                    A_EXCPC:   kind_o = K_EXCPC;
                    A_EXCSR:   kind_o = K_EXCSR;
                    A_MACLO:   kind_o = K_MACLO;
                    A_MACHI:   kind_o = K_MACHI;
                    A_TIMER:   kind_o = K_TIMER;
                    default:   kind_o = K_BAD;
                endcase
            end
        end
    end

    assign idx_o = IDX_W'(addr_i - SHADOW_BASE);

    always_comb begin
        act_o = '0;
        if (valid_i) begin
            if (!priv_i) begin
                act_o.warn = 1'b1;
            end else if (write_i) begin
                if (kind_storable(kind_o)) begin
                    act_o.wr_store = 1'b1;
                end else if (kind_o == K_NEXTPC) begin
                    act_o.redirect = 1'b1;
                end else if (kind_o == K_TIMER) begin
                    act_o.warn = (wdata_i != '0);
                end else begin
                    act_o.warn = 1'b1;
                end
            end else begin
                act_o.rd_ok = kind_readable(kind_o);
                act_o.warn  = !kind_readable(kind_o);
            end
        end
    end

endmodule

// File: rtl/spr_store.sv
module spr_store
    import spr_gate_pkg::*;
#(
    parameter int        SHADOW_DEPTH = 512,
    parameter spr_word_t VERSION_VAL  = 32'h0102_0003,
    parameter spr_word_t UNITS_VAL    = 32'h0000_0105,
    parameter spr_word_t CFG_VAL      = 32'h0000_0020,
    localparam int       IDX_W        = $clog2(SHADOW_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  spr_kind_e        kind_i,
    input  logic [IDX_W-1:0] idx_i,
    input  spr_word_t        wdata_i,
    input  spr_word_t        prev_pc_i,
    output spr_word_t        rd_value_o
);

    spr_word_t status_q, fpcs_q, excpc_q, excsr_q, maclo_q, machi_q;
    spr_word_t shadow_q [SHADOW_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= force_fixed_one('0);
            fpcs_q   <= '0;
            excpc_q  <= '0;
            excsr_q  <= '0;
            maclo_q  <= '0;
            machi_q  <= '0;
        end else if (wr_i) begin
            case (kind_i)
                K_STATUS: status_q <= force_fixed_one(wdata_i);
                K_FPCS:   fpcs_q   <= wdata_i;
                K_EXCPC:  excpc_q  <= wdata_i;
                K_EXCSR:  excsr_q  <= wdata_i;
                K_MACLO:  maclo_q  <= wdata_i;
                K_MACHI:  machi_q  <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i && kind_i == K_SHADOW) begin
            shadow_q[idx_i] <= wdata_i;
        end
    end

    always_comb begin
        case (kind_i)
            K_VERSION: rd_value_o = VERSION_VAL;
            K_UNITS:   rd_value_o = UNITS_VAL;
            K_CFG:     rd_value_o = CFG_VAL;
            K_STATUS:  rd_value_o = status_q;
            K_PREVPC:  rd_value_o = prev_pc_i;
            K_FPCS:    rd_value_o = fpcs_q;
            K_EXCPC:   rd_value_o = excpc_q;
            K_MACLO:   rd_value_o = maclo_q;
            K_MACHI:   rd_value_o = machi_q;
            K_SHADOW:  rd_value_o = shadow_q[idx_i];
            default:   rd_value_o = '0;
        endcase
    end

    AST_STATUS_FIXED_ONE: assert property (@(posedge clk) disable iff (rst)
        status_q[FO_BIT]);  // R5

    AST_IDLE_HOLDS_REGS: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable({status_q, fpcs_q, excpc_q, excsr_q, maclo_q, machi_q}));  // R8

endmodule

// File: rtl/spr_resp.sv
module spr_resp
    import spr_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid_i,
    input  logic      write_i,
    input  spr_addr_t addr_i,
    input  spr_word_t wdata_i,
    input  spr_act_t  act_i,
    input  spr_word_t rd_value_i,
    output logic      rf_we_o,
    output logic      rf_re_o,
    output logic      rd_valid_o,
    output spr_word_t rd_data_o,
    output logic      redir_valid_o,
    output spr_word_t redir_pc_o,
    output logic      warn_o,
    output spr_addr_t warn_addr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_we_o       <= 1'b0;
            rf_re_o       <= 1'b0;
            rd_valid_o    <= 1'b0;
            rd_data_o     <= '0;
            redir_valid_o <= 1'b0;
            redir_pc_o    <= '0;
            warn_o        <= 1'b0;
            warn_addr_o   <= '0;
        end else begin
            rf_we_o       <= act_i.wr_store;
            rf_re_o       <= act_i.rd_ok;
            rd_valid_o    <= valid_i && !write_i;
            rd_data_o     <= act_i.rd_ok ? rd_value_i : '0;
            redir_valid_o <= act_i.redirect;
            redir_pc_o    <= act_i.redirect ? wdata_i : '0;
            warn_o        <= act_i.warn;
            warn_addr_o   <= act_i.warn ? addr_i : '0;
        end
    end

    AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && !rf_re_o) |-> (rd_data_o == '0));  // R3

    AST_REDIRECT_ALONE: assert property (@(posedge clk) disable iff (rst)
        redir_valid_o |-> (!rf_we_o && !warn_o && !rd_valid_o));  // R6

    AST_WARN_CARRIES_ADDR: assert property (@(posedge clk) disable iff (rst)
        warn_o |-> (warn_addr_o == $past(addr_i)));  // R9

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $countones({rf_we_o, rf_re_o, redir_valid_o, warn_o}) <= 1);  // R4

endmodule

// File: rtl/spr_gate.sv
module spr_gate
    import spr_gate_pkg::*;
#(
    parameter spr_addr_t SPR_LIMIT    = 16'h6000,
    parameter spr_addr_t SHADOW_BASE  = 16'h0400,
    parameter int        SHADOW_DEPTH = 512,
    parameter spr_word_t VERSION_VAL  = 32'h0102_0003,
    parameter spr_word_t UNITS_VAL    = 32'h0000_0105,
    parameter spr_word_t CFG_VAL      = 32'h0000_0020
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid_i,
    input  logic        req_write_i,
    input  logic [15:0] req_addr_i,
    input  logic [31:0] req_wdata_i,
    input  logic        mode_super_i,
    input  logic        mode_usr_spr_i,
    input  logic [31:0] prev_pc_i,
    output logic        rf_we_o,
    output logic        rf_re_o,
    output logic        rd_valid_o,
    output logic [31:0] rd_data_o,
    output logic        redir_valid_o,
    output logic [31:0] redir_pc_o,
    output logic        warn_o,
    output logic [15:0] warn_addr_o
);

    localparam int IDX_W = $clog2(SHADOW_DEPTH);

    logic             priv;
    spr_kind_e        kind;
    logic [IDX_W-1:0] idx;
    spr_act_t         act;
    spr_word_t        rd_value;

    assign priv = mode_super_i || mode_usr_spr_i;

    spr_decode #(
        .SPR_LIMIT   (SPR_LIMIT),
        .SHADOW_BASE (SHADOW_BASE),
        .SHADOW_DEPTH(SHADOW_DEPTH)
    ) u_decode (
        .valid_i(req_valid_i),
        .write_i(req_write_i),
        .addr_i (req_addr_i),
        .wdata_i(req_wdata_i),
        .priv_i (priv),
        .kind_o (kind),
        .idx_o  (idx),
        .act_o  (act)
    );

    spr_store #(
        .SHADOW_DEPTH(SHADOW_DEPTH),
        .VERSION_VAL (VERSION_VAL),
        .UNITS_VAL   (UNITS_VAL),
        .CFG_VAL     (CFG_VAL)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (act.wr_store),
        .kind_i    (kind),
        .idx_i     (idx),
        .wdata_i   (req_wdata_i),
        .prev_pc_i (prev_pc_i),
        .rd_value_o(rd_value)
    );

    spr_resp u_resp (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (req_valid_i),
        .write_i      (req_write_i),
        .addr_i       (req_addr_i),
        .wdata_i      (req_wdata_i),
        .act_i        (act),
        .rd_value_i   (rd_value),
        .rf_we_o      (rf_we_o),
        .rf_re_o      (rf_re_o),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .redir_valid_o(redir_valid_o),
        .redir_pc_o   (redir_pc_o),
        .warn_o       (warn_o),
        .warn_addr_o  (warn_addr_o)
    );

    AST_UNPRIV_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !mode_super_i && !mode_usr_spr_i)
            |=> (warn_o && !rf_we_o && !redir_valid_o && !rf_re_o));  // R1

    AST_RANGE_WARN: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_addr_i >= SPR_LIMIT) |=> warn_o);  // R2

    AST_TIMER_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i && priv && req_addr_i == A_TIMER && req_wdata_i == '0)
            |=> (!warn_o && !rf_we_o && !redir_valid_o));  // R7

endmodule

// File: tb/spr_gate_tb.sv
module spr_gate_tb;
    import spr_gate_pkg::*;

    localparam spr_addr_t LIMIT   = 16'h6000;
    localparam spr_addr_t SH_BASE = 16'h0400;
    localparam int        SH_DEP  = 512;
    localparam spr_word_t VER_V   = 32'h0102_0003;
    localparam spr_word_t UNI_V   = 32'h0000_0105;
    localparam spr_word_t CFG_V   = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        mode_super_i = 1'b1, mode_usr_spr_i = 1'b0;
    logic [31:0] prev_pc_i = 32'h1234_5678;
    logic        rf_we_o, rf_re_o, rd_valid_o, redir_valid_o, warn_o;
    logic [31:0] rd_data_o, redir_pc_o;
    logic [15:0] warn_addr_o;

    always #10 clk = ~clk;  // 50 MHz

    spr_gate #(
        .SPR_LIMIT(LIMIT), .SHADOW_BASE(SH_BASE), .SHADOW_DEPTH(SH_DEP),
        .VERSION_VAL(VER_V), .UNITS_VAL(UNI_V), .CFG_VAL(CFG_V)
    ) u_dut (.*);

    typedef struct {
        logic        we, re, rdv, rv, wn;
        logic [31:0] rdata, rpc;
        logic [15:0] waddr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, failures = 0;
    bit done = 0;

    // Independent model of the register contents
    spr_word_t m_status = 32'h0000_8000;
    spr_word_t m_fpcs = '0, m_excpc = '0, m_excsr = '0, m_maclo = '0, m_machi = '0;
    spr_word_t m_sh [SH_DEP];

    function automatic bit in_shadow(spr_addr_t a);
        return (a >= SH_BASE) && (32'(a) < 32'(SH_BASE) + SH_DEP);
    endfunction

    function automatic bit m_read(spr_addr_t a, output spr_word_t v);
        v = '0;
        if (a >= LIMIT) return 0;
        if (in_shadow(a)) begin v = m_sh[a - SH_BASE]; return 1; end
        case (a)
            A_VERSION: v = VER_V;
            A_UNITS:   v = UNI_V;
            A_CFG:     v = CFG_V;
            A_STATUS:  v = m_status;
            A_PREVPC:  v = prev_pc_i;
            A_FPCS:    v = m_fpcs;
            A_EXCPC:   v = m_excpc;
            A_MACLO:   v = m_maclo;
            A_MACHI:   v = m_machi;
            default:   return 0;
        endcase
        return 1;
    endfunction

    task automatic req(input bit w, input spr_addr_t a, input spr_word_t d,
                       input bit s, input bit u, input string tag);
        exp_t e;
        spr_word_t v;
        e = '{we:0, re:0, rdv:0, rv:0, wn:0, rdata:0, rpc:0, waddr:0, tag:tag};
        @(negedge clk);
        req_valid_i = 1; req_write_i = w; req_addr_i = a; req_wdata_i = d;
        mode_super_i = s; mode_usr_spr_i = u;
        if (!w) begin
            e.rdv = 1;
            if ((s || u) && m_read(a, v)) begin e.re = 1; e.rdata = v; end
            else e.wn = 1;
        end else if (!(s || u) || a >= LIMIT) begin
            e.wn = 1;
        end else if (in_shadow(a)) begin
            e.we = 1; m_sh[a - SH_BASE] = d;
        end else begin
            case (a)
                A_STATUS: begin e.we = 1; m_status = d | 32'h0000_8000; end
                A_FPCS:   begin e.we = 1; m_fpcs = d; end
                A_EXCPC:  begin e.we = 1; m_excpc = d; end
                A_EXCSR:  begin e.we = 1; m_excsr = d; end
                A_MACLO:  begin e.we = 1; m_maclo = d; end
                A_MACHI:  begin e.we = 1; m_machi = d; end
                A_NEXTPC: begin e.rv = 1; e.rpc = d; end
                A_TIMER:  e.wn = (d != 0);
                default:  e.wn = 1;
            endcase
        end
        if (e.wn) e.waddr = a;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid_i = 0; req_write_i = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compares each response one cycle after its request
    initial begin
        bit pend;
        exp_t e;
        forever begin
            @(posedge clk);
            pend = req_valid_i && !rst;
            @(negedge clk);
            if (pend) begin
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL R9 response without expected item");
                end else begin
                    e = q.pop_front();
                    if (rf_we_o !== e.we || rf_re_o !== e.re || rd_valid_o !== e.rdv ||
                        rd_data_o !== e.rdata || redir_valid_o !== e.rv ||
                        redir_pc_o !== e.rpc || warn_o !== e.wn || warn_addr_o !== e.waddr) begin
                        failures++;
                        $display("FAIL %s: got we=%b re=%b rdv=%b rd=%h rv=%b pc=%h wn=%b wa=%h exp we=%b re=%b rdv=%b rd=%h rv=%b pc=%h wn=%b wa=%h",
                            e.tag, rf_we_o, rf_re_o, rd_valid_o, rd_data_o, redir_valid_o,
                            redir_pc_o, warn_o, warn_addr_o, e.we, e.re, e.rdv, e.rdata,
                            e.rv, e.rpc, e.wn, e.waddr);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R10 outputs held at zero during reset
        if ({rf_we_o, rf_re_o, rd_valid_o, rd_data_o, redir_valid_o, redir_pc_o, warn_o, warn_addr_o} !== '0) begin
            failures++;
            $display("FAIL R10 reset outputs got %b/%b/%b/%h/%b/%h/%b/%h exp all zero",
                rf_we_o, rf_re_o, rd_valid_o, rd_data_o, redir_valid_o, redir_pc_o, warn_o, warn_addr_o);
        end
        rst = 0;
        // R5 reset status value and fixed-one bit
        req(0, A_STATUS, 0, 1, 0, "R5 status after reset");
        req(1, A_STATUS, 32'h0000_0001, 1, 0, "R5 status write low");
        req(0, A_STATUS, 0, 1, 0, "R5 status readback forced bit");
        req(1, A_STATUS, 32'hFFFF_7FFF, 1, 0, "R5 status write all but bit15");
        req(0, A_STATUS, 0, 1, 0, "R5 status readback all ones");
        // R3 constants and previous PC
        req(0, A_VERSION, 0, 1, 0, "R3 version");
        req(0, A_UNITS, 0, 1, 0, "R3 units");
        req(0, A_CFG, 0, 1, 0, "R3 config");
        req(0, A_PREVPC, 0, 1, 0, "R3 prev pc");
        idle(1);
        prev_pc_i = 32'hCAFE_0004;
        req(0, A_PREVPC, 0, 1, 0, "R3 prev pc changed");
        // R4 stores and readback, R9 write then read next cycle
        req(1, A_FPCS, 32'h0000_00A5, 1, 0, "R4 fpcs write");
        req(0, A_FPCS, 0, 1, 0, "R4 R9 fpcs readback");
        req(1, A_EXCPC, 32'h0000_1F00, 1, 0, "R4 excpc write");
        req(1, A_MACLO, 32'h1111_2222, 1, 0, "R4 maclo write");
        req(1, A_MACHI, 32'h3333_4444, 1, 0, "R4 machi write");
        req(1, A_EXCSR, 32'h0000_8001, 1, 0, "R4 excsr write");
        req(0, A_EXCPC, 0, 1, 0, "R4 excpc readback");
        req(0, A_MACLO, 0, 1, 0, "R4 maclo readback");
        req(0, A_MACHI, 0, 1, 0, "R4 machi readback");
        req(1, SH_BASE, 32'hAAAA_0001, 1, 0, "R4 shadow first write");
        req(1, 16'h05FF, 32'hBBBB_0002, 1, 0, "R4 shadow last write");
        req(0, 16'h05FF, 0, 1, 0, "R4 shadow last read");
        req(0, SH_BASE, 0, 1, 0, "R4 shadow first read");
        idle(2);
        // R6 next-PC redirect
        req(1, A_NEXTPC, 32'h0000_2000, 1, 0, "R6 nextpc redirect");
        req(0, A_NEXTPC, 0, 1, 0, "R8 nextpc read refused");
        // R7 timer mode
        req(1, A_TIMER, 32'h0, 1, 0, "R7 timer zero silent");
        req(1, A_TIMER, 32'h5, 1, 0, "R7 timer nonzero warns");
        req(0, A_TIMER, 0, 1, 0, "R8 timer read refused");
        // R8 other addresses
        req(0, A_EXCSR, 0, 1, 0, "R8 excsr read refused");
        req(1, A_VERSION, 32'hFFFF_FFFF, 1, 0, "R8 version write refused");
        req(0, A_VERSION, 0, 1, 0, "R8 version unchanged");
        req(1, 16'h0003, 32'h77, 1, 0, "R8 unmapped write");
        req(0, 16'h0600, 0, 1, 0, "R8 past shadow read");
        // R2 limit
        req(0, LIMIT, 0, 1, 0, "R2 read at limit");
        req(1, 16'h7FFF, 32'h9, 1, 0, "R2 write above limit");
        req(0, 16'hFFFF, 0, 1, 0, "R2 read top");
        // R1 privilege
        req(1, A_MACLO, 32'hDEAD_BEEF, 0, 0, "R1 unpriv write dropped");
        req(0, A_MACLO, 0, 1, 0, "R1 maclo unchanged");
        req(0, A_STATUS, 0, 0, 0, "R1 unpriv read zero");
        req(0, A_MACLO, 0, 0, 1, "R1 user permission read");
        req(1, A_FPCS, 32'h0000_0003, 0, 1, "R1 user permission write");
        req(0, A_FPCS, 0, 1, 0, "R1 fpcs after user write");
        idle(4);
        done = 1;
        if (q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R9 %0d responses missing", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule